// File: doc/BRIEF.md
# Fiber PHY Mode Control Register with MII Isolation

This block holds the basic mode control word of a fiber Ethernet transceiver and the datapath logic that the word steers. A management port updates the word and returns it. The port carries a register address, 16 bits of write data, a write strobe and combinational read data. Serial management framing sits outside the block; the port here is already parallel.

The isolate bit drives a gate on the MII. When the bit is set, the enables of every transceiver-driven MII output drop low, so those outputs float. The transmit inputs (enable, error, nibble) are also forced to zero before they reach the core. The isolate bit comes out of reset set only when the strapped transceiver address is zero.

The duplex and loopback bits leave the block as mode outputs. In loopback mode, a collision-test generator can take over the collision output. It counts bit-time ticks after transmit enable rises and raises the collision signal after a fixed, parameterised number of ticks (at most 512). It drops the signal again a few ticks after transmit enable falls.

Top module: `fx_modectl`

## Requirements
- R1: The register resets synchronously. After reset it reads 0x0400 (bit 10 set) when `phy_addr` is 0, and 0x0000 for any other strapped address.
- R2: A write with `mgmt_addr == REG_ADDR` stores bits 15..10, 8 and 7 of the write data, and a read at that address returns them. A read at any other address returns 0, and a write to any other address leaves the register unchanged.
- R3: Bit 9 (restart negotiation) always reads 0, and any value written to it is discarded.
- R4: Bits 6..0 always read 0, and writing them has no effect.
- R5: While bit 10 is 1, `mii_clk_oe`, `mii_rx_oe` and `mii_stat_oe` are 0, and `tx_en_core`, `tx_er_core` and `txd_core` are 0 whatever the MII inputs are. While bit 10 is 0, the enables are 1 and the transmit inputs pass through unchanged.
- R6: The management port keeps working while isolated. A write that clears bit 10 restores the enables on the next cycle.
- R7: `duplex_full` equals bit 8 while bit 14 (loopback) is 0, and it is 0 while loopback is set.
- R8: `loopback_en` equals bit 14.
- R9: With bits 14 and 7 both set, `col_o` rises in the cycle after the COL_DLY-th `bit_tick` counted while transmit enable is high (1 <= COL_DLY <= 512).
- R10: With the test active and `col_o` high, after transmit enable falls `col_o` drops in the cycle after the REL_DLY-th `bit_tick` (0 <= REL_DLY <= 4). When REL_DLY is 0, it drops on the next cycle.
- R11: When bit 7 or bit 14 is 0, `col_o` equals `col_core`, and the test generator holds no state.
- R12: If transmit enable falls before `col_o` has risen, the tick count restarts from zero at the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | ADDR_W | Strapped transceiver address |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_rdata | output | 16 | Management read data (combinational) |
| tx_en_in | input | 1 | MII transmit enable from the MAC |
| tx_er_in | input | 1 | MII transmit error from the MAC |
| txd_in | input | 4 | MII transmit nibble from the MAC |
| tx_en_core | output | 1 | Gated transmit enable to the core |
| tx_er_core | output | 1 | Gated transmit error to the core |
| txd_core | output | 4 | Gated transmit nibble to the core |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| col_core | input | 1 | Collision from normal operation |
| col_o | output | 1 | Collision toward the MII |
| mii_clk_oe | output | 1 | Output enable for the MII clocks |
| mii_rx_oe | output | 1 | Output enable for receive data, valid and error |
| mii_stat_oe | output | 1 | Output enable for collision and carrier sense |
| duplex_full | output | 1 | Effective full-duplex mode |
| loopback_en | output | 1 | Loopback mode |

## Verification
The bench builds the block with COL_DLY = 6 and REL_DLY = 2 and keeps the defaults for the address width and register address. These small values let the bench count the exact tick on which collision rises and falls. They also make a restart after an early transmit-enable drop show up as a visibly early assertion. The checker holds the same windows against the absolute bounds of 512 and 4 ticks, so the bounds are covered as well as the exact values.

// File: rtl/fx_modectl_pkg.sv
package fx_modectl_pkg;

  localparam int CW = 16;

  // bit positions of the control word
  localparam int B_LPBK  = 14;
  localparam int B_ISO   = 10;
  localparam int B_DPLX  = 8;
  localparam int B_CTEST = 7;

  // writable bits: 15..10, 8, 7
  localparam logic [CW-1:0] CTL_WMASK = 16'hFD80;

  // upper bound of the collision assertion window in bit times
  localparam int COL_DLY_MAX = 512;
  localparam int REL_DLY_MAX = 4;
  localparam int TICK_CW     = $clog2(COL_DLY_MAX) + 1;

  function automatic logic [CW-1:0] ctl_store(input logic [CW-1:0] wd);
    return wd & CTL_WMASK;
  endfunction

  function automatic logic [CW-1:0] ctl_reset_word(input logic addr_is_zero);
    logic [CW-1:0] w;
    w = '0;
    w[B_ISO] = addr_is_zero;
    return w;
  endfunction

  function automatic logic dplx_effective(input logic dplx, input logic lpbk);
    return dplx & ~lpbk;
  endfunction

endpackage

// File: rtl/fx_ctlreg.sv
module fx_ctlreg
  import fx_modectl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [CW-1:0]     mgmt_wdata,
  input  logic              mgmt_we,
  output logic [CW-1:0]     mgmt_rdata,
  output logic              iso_bit,
  output logic              lpbk_bit,
  output logic              dplx_bit,
  output logic              ctest_bit
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic [CW-1:0] ctl_q;
  logic          addr_hit;
  logic          wr_hit;

  assign addr_hit = (mgmt_addr == HIT_ADDR);
  assign wr_hit   = mgmt_we & addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= ctl_reset_word(phy_addr == '0);
    end else if (wr_hit) begin
      ctl_q <= ctl_store(mgmt_wdata);
    end
  end

  assign mgmt_rdata = addr_hit ? ctl_q : '0;
  assign iso_bit    = ctl_q[B_ISO];
  assign lpbk_bit   = ctl_q[B_LPBK];
  assign dplx_bit   = ctl_q[B_DPLX];
  assign ctest_bit  = ctl_q[B_CTEST];

endmodule

// File: rtl/fx_isogate.sv
module fx_isogate #(
  parameter int NIB_W = 4
) (
  input  logic             iso,
  input  logic             tx_en_in,
  input  logic             tx_er_in,
  input  logic [NIB_W-1:0] txd_in,
  output logic             tx_en_core,
  output logic             tx_er_core,
  output logic [NIB_W-1:0] txd_core,
  output logic             mii_clk_oe,
  output logic             mii_rx_oe,
  output logic             mii_stat_oe
);

  logic pass;
  assign pass = ~iso;

  assign tx_en_core  = tx_en_in & pass;
  assign tx_er_core  = tx_er_in & pass;
  assign txd_core    = txd_in & {NIB_W{pass}};
  assign mii_clk_oe  = pass;
  assign mii_rx_oe   = pass;
  assign mii_stat_oe = pass;

endmodule

// File: rtl/fx_coltest.sv
module fx_coltest
  import fx_modectl_pkg::*;
#(
  parameter int COL_DLY = 64,
  parameter int REL_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic tx_en,
  input  logic bit_tick,
  output logic col_test,
  output logic col_set_evt,
  output logic col_clr_evt
);

  localparam int SET_I = (COL_DLY > 0) ? COL_DLY - 1 : 0;
  localparam int CLR_I = (REL_DLY > 0) ? REL_DLY - 1 : 0;
  localparam logic [TICK_CW-1:0] SET_LAST = TICK_CW'(SET_I);
  localparam logic [TICK_CW-1:0] CLR_LAST = TICK_CW'(CLR_I);

  logic [TICK_CW-1:0] cnt_q;
  logic               col_q;
  logic               rel_now;

  assign col_set_evt = test_en & tx_en & ~col_q & bit_tick & (cnt_q == SET_LAST);

  generate
    if (REL_DLY == 0) begin : g_rel_immediate
      assign rel_now = 1'b1;
    end else begin : g_rel_counted
      assign rel_now = bit_tick & (cnt_q == CLR_LAST);
    end
  endgenerate

  assign col_clr_evt = test_en & ~tx_en & col_q & rel_now;

  always_ff @(posedge clk) begin
    if (!rst_n || !test_en) begin
      cnt_q <= '0;
      col_q <= 1'b0;
    end else if (tx_en) begin
      if (col_q) begin
        cnt_q <= '0;
      end else if (col_set_evt) begin
        cnt_q <= '0;
        col_q <= 1'b1;
      end else if (bit_tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (!col_q) begin
        cnt_q <= '0;
      end else if (col_clr_evt) begin
        cnt_q <= '0;
        col_q <= 1'b0;
      end else if (bit_tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign col_test = col_q;

endmodule

// File: rtl/fx_modectl.sv
module fx_modectl
  import fx_modectl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 0,
  parameter int COL_DLY  = 64,
  parameter int REL_DLY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  input  logic              mgmt_we,
  output logic [15:0]       mgmt_rdata,
  input  logic              tx_en_in,
  input  logic              tx_er_in,
  input  logic [3:0]        txd_in,
  output logic              tx_en_core,
  output logic              tx_er_core,
  output logic [3:0]        txd_core,
  input  logic              bit_tick,
  input  logic              col_core,
  output logic              col_o,
  output logic              mii_clk_oe,
  output logic              mii_rx_oe,
  output logic              mii_stat_oe,
  output logic              duplex_full,
  output logic              loopback_en
);

  logic iso_bit, lpbk_bit, dplx_bit, ctest_bit;
  logic test_en;
  logic col_test, col_set_evt, col_clr_evt;

  fx_ctlreg #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_addr  (phy_addr),
    .mgmt_addr (mgmt_addr),
    .mgmt_wdata(mgmt_wdata),
    .mgmt_we   (mgmt_we),
    .mgmt_rdata(mgmt_rdata),
    .iso_bit   (iso_bit),
    .lpbk_bit  (lpbk_bit),
    .dplx_bit  (dplx_bit),
    .ctest_bit (ctest_bit)
  );

  fx_isogate #(.NIB_W(4)) u_gate (
    .iso        (iso_bit),
    .tx_en_in   (tx_en_in),
    .tx_er_in   (tx_er_in),
    .txd_in     (txd_in),
    .tx_en_core (tx_en_core),
    .tx_er_core (tx_er_core),
    .txd_core   (txd_core),
    .mii_clk_oe (mii_clk_oe),
    .mii_rx_oe  (mii_rx_oe),
    .mii_stat_oe(mii_stat_oe)
  );

  assign test_en = lpbk_bit & ctest_bit;

  fx_coltest #(
    .COL_DLY(COL_DLY),
    .REL_DLY(REL_DLY)
  ) u_col (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .tx_en      (tx_en_core),
    .bit_tick   (bit_tick),
    .col_test   (col_test),
    .col_set_evt(col_set_evt),
    .col_clr_evt(col_clr_evt)
  );

  assign col_o       = test_en ? col_test : col_core;
  assign duplex_full = dplx_effective(dplx_bit, lpbk_bit);
  assign loopback_en = lpbk_bit;

endmodule

// File: rtl/fx_modectl_chk.sv
module fx_modectl_chk #(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 0,
  parameter int COL_DLY  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [15:0]       mgmt_rdata,
  input logic              iso_bit,
  input logic              test_en,
  input logic              mii_rx_oe,
  input logic              mii_stat_oe,
  input logic              tx_en_core,
  input logic [3:0]        txd_core,
  input logic              bit_tick,
  input logic              col_o,
  input logic              col_core,
  input logic              col_set_evt
);

  logic        rst_d;
  logic [10:0] set_cnt;
  logic [10:0] rel_cnt;

  always_ff @(posedge clk) rst_d <= rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n || !test_en || !tx_en_core || col_o) set_cnt <= '0;
    else if (bit_tick) set_cnt <= set_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !test_en || tx_en_core || !col_o) rel_cnt <= '0;
    else if (bit_tick) rel_cnt <= rel_cnt + 1'b1;
  end

  // R1
  a_r1_iso_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_d) |-> (iso_bit == ($past(phy_addr) == '0)));

  // R3, R4
  a_r3_r4_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == ADDR_W'(REG_ADDR)) |-> (mgmt_rdata[9] == 1'b0 && mgmt_rdata[6:0] == 7'd0));

  // R5
  a_r5_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    iso_bit |-> (!mii_rx_oe && !mii_stat_oe && !tx_en_core && txd_core == 4'd0));

  // R9
  a_r9_set_window: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cnt <= 11'(COL_DLY)) && (set_cnt <= 11'd512));

  // R9
  a_r9_rise_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    col_set_evt |=> (col_o && test_en));

  // R10
  a_r10_release_window: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= 11'd4);

  // R11
  a_r11_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en) |-> (col_o == col_core));

endmodule

bind fx_modectl fx_modectl_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR),
  .COL_DLY (COL_DLY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phy_addr   (phy_addr),
  .mgmt_addr  (mgmt_addr),
  .mgmt_rdata (mgmt_rdata),
  .iso_bit    (iso_bit),
  .test_en    (test_en),
  .mii_rx_oe  (mii_rx_oe),
  .mii_stat_oe(mii_stat_oe),
  .tx_en_core (tx_en_core),
  .txd_core   (txd_core),
  .bit_tick   (bit_tick),
  .col_o      (col_o),
  .col_core   (col_core),
  .col_set_evt(col_set_evt)
);

// File: tb/fx_modectl_bench.sv
`timescale 1ns/1ps
module fx_modectl_bench;

  localparam int AW = 5;
  localparam int CD = 6;
  localparam int RD = 2;
  localparam logic [15:0] KEEP = 16'hFD80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] phy_addr = '0;
  logic [AW-1:0] mgmt_addr = '0;
  logic [15:0]   mgmt_wdata = '0;
  logic          mgmt_we = 1'b0;
  logic [15:0]   mgmt_rdata;
  logic          tx_en_in = 1'b0, tx_er_in = 1'b0;
  logic [3:0]    txd_in = '0;
  logic          tx_en_core, tx_er_core;
  logic [3:0]    txd_core;
  logic          bit_tick = 1'b0, col_core = 1'b0, col_o;
  logic          mii_clk_oe, mii_rx_oe, mii_stat_oe, duplex_full, loopback_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fx_modectl #(.ADDR_W(AW), .REG_ADDR(0), .COL_DLY(CD), .REL_DLY(RD)) u_fx_modectl (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_we(mgmt_we), .mgmt_rdata(mgmt_rdata),
    .tx_en_in(tx_en_in), .tx_er_in(tx_er_in), .txd_in(txd_in),
    .tx_en_core(tx_en_core), .tx_er_core(tx_er_core), .txd_core(txd_core),
    .bit_tick(bit_tick), .col_core(col_core), .col_o(col_o),
    .mii_clk_oe(mii_clk_oe), .mii_rx_oe(mii_rx_oe), .mii_stat_oe(mii_stat_oe),
    .duplex_full(duplex_full), .loopback_en(loopback_en)
  );

  // {write data, expected read back}
  localparam logic [31:0] VEC [8] = '{
    {16'hFFFF, 16'hFD80}, {16'h0200, 16'h0000}, {16'h007F, 16'h0000},
    {16'h8800, 16'h8800}, {16'h4180, 16'h4180}, {16'h0100, 16'h0100},
    {16'h3000, 16'h3000}, {16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [AW-1:0] a);
    @(negedge clk);
    rst_n = 1'b0;
    phy_addr = a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = d; mgmt_we = 1'b1;
    @(negedge clk);
    mgmt_we = 1'b0; mgmt_addr = '0;
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  initial begin
    int rise_k, fall_k;
    logic [15:0] wd, ex;

    // R1 and R5 with address 0
    do_reset('0);
    check(mgmt_rdata == 16'h0400, "R1 reset addr0", mgmt_rdata, 16'h0400);
    check({mii_clk_oe, mii_rx_oe, mii_stat_oe} == 3'b000, "R5 oe isolated",
          {mii_clk_oe, mii_rx_oe, mii_stat_oe}, 0);
    tx_en_in = 1'b1; tx_er_in = 1'b1; txd_in = 4'hF;
    #1;
    check({tx_en_core, tx_er_core, txd_core} == 6'd0, "R5 inputs masked",
          {tx_en_core, tx_er_core, txd_core}, 0);
    tx_en_in = 1'b0; tx_er_in = 1'b0; txd_in = 4'h0;

    // R1 nonzero address
    do_reset(5'd3);
    check(mgmt_rdata == 16'h0000, "R1 reset addr3", mgmt_rdata, 0);
    check({mii_clk_oe, mii_rx_oe, mii_stat_oe} == 3'b111, "R5 oe active",
          {mii_clk_oe, mii_rx_oe, mii_stat_oe}, 3'b111);
    txd_in = 4'hA; tx_en_in = 1'b1;
    #1;
    check(txd_core == 4'hA && tx_en_core, "R5 pass through", {tx_en_core, txd_core}, 5'h1A);
    tx_en_in = 1'b0; txd_in = 4'h0;

    // R6 management while isolated
    do_reset('0);
    wr('0, 16'h0000);
    check(mgmt_rdata == 16'h0000 && mii_rx_oe, "R6 write while isolated",
          {mii_rx_oe, mgmt_rdata}, 17'h10000);

    // R2, R3, R4, R7, R8 vector table
    foreach (VEC[i]) begin
      wd = VEC[i][31:16];
      ex = VEC[i][15:0];
      wr('0, wd);
      check(mgmt_rdata == ex, "R2/R3/R4 readback", mgmt_rdata, ex);
      check(mgmt_rdata[9] == 1'b0, "R3 restart bit", mgmt_rdata[9], 0);
      check(mgmt_rdata[6:0] == 7'd0, "R4 reserved bits", mgmt_rdata[6:0], 0);
      check(duplex_full == (ex[8] & ~ex[14]), "R7 duplex", duplex_full, ex[8] & ~ex[14]);
      check(loopback_en == ex[14], "R8 loopback", loopback_en, ex[14]);
    end

    // R2 other address
    wr('0, 16'h0100);
    wr(5'd1, 16'hFFFF);
    mgmt_addr = 5'd1; #1;
    check(mgmt_rdata == 16'h0000, "R2 other address reads 0", mgmt_rdata, 0);
    mgmt_addr = '0; #1;
    check(mgmt_rdata == 16'h0100, "R2 other address write ignored", mgmt_rdata, 16'h0100);

    // R9 collision assertion tick count
    wr('0, 16'h4080);
    @(negedge clk) tx_en_in = 1'b1;
    rise_k = 0;
    for (int k = 1; k <= CD + 2; k++) begin
      tick();
      if (col_o && rise_k == 0) rise_k = k;
    end
    check(rise_k == CD, "R9 col rise tick", rise_k, CD);

    // R10 release tick count
    tx_en_in = 1'b0;
    @(negedge clk);
    check(col_o == 1'b1, "R10 col held until ticks", col_o, 1);
    fall_k = 0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      if (!col_o && fall_k == 0) fall_k = k;
    end
    check(fall_k == RD && fall_k <= 4, "R10 col fall tick", fall_k, RD);

    // R12 restart after early drop
    @(negedge clk) tx_en_in = 1'b1;
    for (int k = 0; k < 3; k++) tick();
    tx_en_in = 1'b0;
    @(negedge clk) tx_en_in = 1'b1;
    rise_k = 0;
    for (int k = 1; k <= CD + 1; k++) begin
      tick();
      if (col_o && rise_k == 0) rise_k = k;
    end
    check(rise_k == CD, "R12 count restarts", rise_k, CD);
    tx_en_in = 1'b0;
    for (int k = 0; k < 3; k++) tick();

    // R11 pass through when the test is off
    wr('0, 16'h4000);
    col_core = 1'b1; #1;
    check(col_o == 1'b1, "R11 col follows core (lpbk only)", col_o, 1);
    col_core = 1'b0;
    @(negedge clk) tx_en_in = 1'b1;
    for (int k = 0; k < CD + 2; k++) tick();
    check(col_o == 1'b0, "R11 no test col (lpbk only)", col_o, 0);
    tx_en_in = 1'b0;
    wr('0, 16'h0080);
    @(negedge clk) tx_en_in = 1'b1;
    for (int k = 0; k < CD + 2; k++) tick();
    check(col_o == 1'b0, "R11 no test col (ctest only)", col_o, 0);
    col_core = 1'b1; #1;
    check(col_o == 1'b1, "R11 col follows core (ctest only)", col_o, 1);
    col_core = 1'b0; tx_en_in = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule